// File: doc/BRIEF.md
# Interrupt Priority Mask Pseudo-Stack Filter

This block gates a single interrupt request against a small priority mask and remembers the masks of interrupted contexts in a short hardware stack. While filtering is on, a request with a level at or above the current mask reaches the CPU. When the CPU accepts an interrupt, the mask in force is pushed onto a four-slot pseudo stack. The mask is then raised to one above the accepted level, saturating at the top level. On return, software writes a pull command that brings the saved mask back.

The stack is one shift register. The newest entry sits in the top slot. A push shifts the older entries down one slot and drops the bottom slot once the stack is full. A pull shifts the entries up and fills the bottom slot with zeros. A bypass setting turns filtering off entirely: requests pass through unchanged and the stack is frozen. Software reaches the block through a byte-wide port that selects either the control/status byte or the stack byte.

Top module: `ipm_stack_filter`

## Requirements
- R1: After reset the control byte reads 0x20 (filtering off, mask 0, empty flag set) and the stack byte reads 0x00.
- R2: Control byte layout: bit 7 filter enable, bit 5 empty flag, bit 4 full flag, bit 3 pull command, bits 1:0 mask. Bits 6, 3 and 2 always read 0. Bits 6, 2, 5 and 4 ignore writes. The stack byte (wr_sel/rd_sel = 1) is read-only, and writes to it are ignored.
- R3: With filtering on, irq_out is 1 exactly when irq_req is 1 and irq_lvl is greater than or equal to the mask.
- R4: With filtering off, irq_out equals irq_req. Neither accepts nor pull commands change the stack, and a pull command written while filtering is off loads the written mask value.
- R5: A control write sets the mask directly and never pushes onto the stack.
- R6: An irq_ack while filtering is on sets the stack to {mask, stack[7:2]} and sets the mask to min(irq_lvl + 1, 3).
- R7: The empty flag is set when the stack holds no entries, and the full flag is set when it holds four.
- R8: A push onto a full stack discards the entry in bits 1:0, and the stack stays full.
- R9: A pull command (bit 3 = 1), written while filtering is already on, loads stack bits 7:6 into the mask and sets the stack to {stack[5:0], 00}. In that write, the pulled value takes priority over the written mask bits.
- R10: A pull on an empty stack sets the mask to 0 and the stack stays empty.
- R11: If a control write and irq_ack fall in the same cycle, the write is applied and the accept is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 stack byte |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 control byte, 1 stack byte |
| rd_data | output | 8 | Read data for the selected byte |
| irq_req | input | 1 | Interrupt request from the source |
| irq_lvl | input | 2 | Priority level of the request |
| irq_ack | input | 1 | CPU accept strobe, one cycle |
| irq_out | output | 1 | Filtered request to the CPU |

## Verification
The hardest state to reach is a full stack that then takes a further push, because it takes five accepts, each with a chosen level, to make every slot hold a distinct known value before the oldest one falls off. The bench chains accepts whose levels rotate the mask through 1, 2, 3, 1, 3. The overflow then loses a recognisable pattern, and the four pulls that follow prove which entry was dropped and that zeros fill from the bottom. Pulling from an empty stack, and a pull command issued while filtering is off but with entries still held, are reached by continuing that same sequence.

// File: rtl/ipm_pkg.sv
package ipm_pkg;

   localparam int unsigned REG_W = 8;

   // control byte bit positions
   localparam int unsigned BIT_EN    = 7;
   localparam int unsigned BIT_EMPTY = 5;
   localparam int unsigned BIT_FULL  = 4;
   localparam int unsigned BIT_PULL  = 3;

   typedef enum logic {
      SEL_CTRL  = 1'b0,
      SEL_STACK = 1'b1
   } reg_sel_e;

   // level + 1, saturating at the highest level
   function automatic logic [1:0] raise_lvl(input logic [1:0] lvl);
      return (lvl == 2'd3) ? 2'd3 : lvl + 2'd1;
   endfunction

endpackage

// File: rtl/ipm_pstack.sv
module ipm_pstack #(
   parameter int unsigned LVL_W = 2,
   parameter int unsigned SLOTS = 4,
   localparam int unsigned STK_W = LVL_W * SLOTS,
   localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pull,
   input  logic [LVL_W-1:0] push_val,
   output logic [LVL_W-1:0] top_val,
   output logic [STK_W-1:0] stk,
   output logic             empty,
   output logic             full
);

   if (SLOTS < 2) begin : g_bad_slots
      $error("ipm_pstack: SLOTS must be at least 2");
   end

   logic [LVL_W-1:0] slot_q [SLOTS];
   logic [CNT_W-1:0] cnt_q;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic [LVL_W-1:0] from_above, from_below;
      if (i == SLOTS - 1) begin : g_top
         assign from_above = push_val;
      end else begin : g_mid_up
         assign from_above = slot_q[i+1];
      end
      if (i == 0) begin : g_bot
         assign from_below = '0;
      end else begin : g_mid_dn
         assign from_below = slot_q[i-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    slot_q[i] <= '0;
         else if (push) slot_q[i] <= from_above;
         else if (pull) slot_q[i] <= from_below;
      end

      assign stk[i*LVL_W +: LVL_W] = slot_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                cnt_q <= '0;
      else if (push && cnt_q != CNT_W'(SLOTS))   cnt_q <= cnt_q + 1'b1;
      else if (pull && cnt_q != '0)              cnt_q <= cnt_q - 1'b1;
   end

   assign top_val = slot_q[SLOTS-1];
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CNT_W'(SLOTS));

   // R6
   push_lands_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> top_val == $past(push_val));

   // R9
   pull_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull |=> slot_q[0] == '0);

   // R8
   full_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full && push |=> full);

   // R7
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && pull) && !(empty && full));

endmodule

// File: rtl/ipm_gate.sv
module ipm_gate #(
   parameter int unsigned LVL_W      = 2,
   parameter bit          HAS_BYPASS = 1'b1
) (
   input  logic             en,
   input  logic             req,
   input  logic [LVL_W-1:0] lvl,
   input  logic [LVL_W-1:0] mask,
   output logic             out
);

   logic pass;
   assign pass = req && (lvl >= mask);

   if (HAS_BYPASS) begin : g_bypass
      assign out = en ? pass : req;
   end else begin : g_always_filter
      logic unused_en;
      assign unused_en = en;
      assign out = pass;
   end

endmodule

// File: rtl/ipm_stack_filter.sv
module ipm_stack_filter
   import ipm_pkg::*;
#(
   parameter int unsigned LVL_W = 2,
   parameter int unsigned SLOTS = 4,
   localparam int unsigned STK_W = LVL_W * SLOTS
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       rd_sel,
   output logic [7:0] rd_data,
   input  logic       irq_req,
   input  logic [1:0] irq_lvl,
   input  logic       irq_ack,
   output logic       irq_out
);

   if (LVL_W != 2) begin : g_bad_lvl
      $error("ipm_stack_filter: LVL_W must be 2 to fit the control byte");
   end
   if (STK_W > REG_W) begin : g_bad_stk
      $error("ipm_stack_filter: stack does not fit one byte");
   end

   logic             en_q;
   logic [LVL_W-1:0] mask_q;
   logic             wr_ctrl, pull_cmd, push;
   logic [LVL_W-1:0] top_val;
   logic [STK_W-1:0] stk;
   logic             empty, full;

   assign wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   assign pull_cmd = wr_ctrl && wr_data[BIT_PULL] && en_q;
   assign push     = irq_ack && en_q && !wr_ctrl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mask_q <= '0;
      end else if (wr_ctrl) begin
         en_q   <= wr_data[BIT_EN];
         mask_q <= pull_cmd ? top_val : wr_data[LVL_W-1:0];
      end else if (push) begin
         mask_q <= raise_lvl(irq_lvl);
      end
   end

   ipm_pstack #(.LVL_W(LVL_W), .SLOTS(SLOTS)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (push),
      .pull     (pull_cmd),
      .push_val (mask_q),
      .top_val  (top_val),
      .stk      (stk),
      .empty    (empty),
      .full     (full)
   );

   ipm_gate #(.LVL_W(LVL_W), .HAS_BYPASS(1'b1)) u_gate (
      .en   (en_q),
      .req  (irq_req),
      .lvl  (irq_lvl),
      .mask (mask_q),
      .out  (irq_out)
   );

   logic [7:0] ctrl_rd;
   always_comb begin
      ctrl_rd            = '0;
      ctrl_rd[BIT_EN]    = en_q;
      ctrl_rd[BIT_EMPTY] = empty;
      ctrl_rd[BIT_FULL]  = full;
      ctrl_rd[LVL_W-1:0] = mask_q;
   end

   assign rd_data = (reg_sel_e'(rd_sel) == SEL_STACK) ? REG_W'(stk) : ctrl_rd;

   // R3
   filter_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_q && irq_req && (irq_lvl < mask_q) |-> !irq_out);

   // R4
   bypass_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> stk == $past(stk));

   // R9
   pull_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pull_cmd |=> mask_q == $past(top_val));

   // R11
   write_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl && irq_ack && !wr_data[BIT_PULL] |=> $stable(stk));

endmodule

// File: tb/sim_ipm_stack_filter.sv
module sim_ipm_stack_filter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_sel = 1'b0;
   logic [7:0] rd_data;
   logic       irq_req = 1'b0;
   logic [1:0] irq_lvl = '0;
   logic       irq_ack = 1'b0;
   logic       irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ipm_stack_filter u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_ack(irq_ack),
      .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic rd_both(input string tag, input logic [7:0] ctl, input logic [7:0] stkv);
      rd_sel = 1'b0; #1; chk({tag, " ctrl"}, rd_data, ctl);
      rd_sel = 1'b1; #1; chk({tag, " stack"}, rd_data, stkv);
      rd_sel = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk); wr_en = 1'b0; wr_sel = 1'b0;
   endtask

   task automatic ack(input logic [1:0] lvl);
      @(negedge clk); irq_ack = 1'b1; irq_lvl = lvl;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic out_is(input string tag, input logic req, input logic [1:0] lvl, input logic exp);
      irq_req = req; irq_lvl = lvl; #1;
      chk(tag, {7'd0, irq_out}, {7'd0, exp});
      irq_req = 1'b0;
   endtask

   task automatic t_reset;
      rd_both("R1 reset", 8'h20, 8'h00);
   endtask

   task automatic t_bypass;
      wr(1'b0, 8'h03);
      rd_both("R2 mask write", 8'h23, 8'h00);
      out_is("R4 bypass pass lvl0", 1'b1, 2'd0, 1'b1);
      out_is("R4 bypass no req", 1'b0, 2'd3, 1'b0);
      ack(2'd2);
      rd_both("R4 ack ignored", 8'h23, 8'h00);
   endtask

   task automatic t_filter;
      wr(1'b0, 8'h82);
      rd_both("R5 no push on write", 8'hA2, 8'h00);
      @(negedge clk);
      out_is("R3 below mask", 1'b1, 2'd1, 1'b0);
      out_is("R3 equal mask", 1'b1, 2'd2, 1'b1);
      out_is("R3 above mask", 1'b1, 2'd3, 1'b1);
      out_is("R3 no req", 1'b0, 2'd3, 1'b0);
   endtask

   task automatic t_push_fill;
      wr(1'b0, 8'h81);
      ack(2'd1); rd_both("R6 push 1", 8'h82, 8'h40);
      ack(2'd3); rd_both("R6 saturate", 8'h83, 8'h90);
      ack(2'd0); rd_both("R6 push 3", 8'h81, 8'hE4);
      ack(2'd2); rd_both("R7 full", 8'h93, 8'h79);
      ack(2'd3); rd_both("R8 overflow", 8'h93, 8'hDE);
   endtask

   task automatic t_pull;
      wr(1'b0, 8'h88); rd_both("R9 pull wins", 8'h83, 8'h78);
      wr(1'b0, 8'h88); rd_both("R9 pull 2", 8'h81, 8'hE0);
      wr(1'b0, 8'h88); rd_both("R9 pull 3", 8'h83, 8'h80);
      wr(1'b0, 8'h88); rd_both("R7 empty again", 8'hA2, 8'h00);
      wr(1'b0, 8'h8B); rd_both("R10 pull empty", 8'hA0, 8'h00);
   endtask

   task automatic t_bypass_pull;
      wr(1'b0, 8'h82);
      ack(2'd0); rd_both("R6 push before bypass", 8'h81, 8'h80);
      wr(1'b0, 8'h01); rd_both("R4 disable", 8'h01, 8'h80);
      wr(1'b0, 8'h0A); rd_both("R4 pull in bypass", 8'h02, 8'h80);
      ack(2'd1); rd_both("R4 ack in bypass", 8'h02, 8'h80);
   endtask

   task automatic t_reserved;
      wr(1'b0, 8'h74); rd_both("R2 reserved bits", 8'h00, 8'h80);
      wr(1'b1, 8'hFF); rd_both("R2 stack read-only", 8'h00, 8'h80);
   endtask

   task automatic t_collide;
      wr(1'b0, 8'h81); rd_both("R11 setup", 8'h81, 8'h80);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'h82;
      irq_ack = 1'b1; irq_lvl = 2'd3;
      @(negedge clk);
      wr_en = 1'b0; irq_ack = 1'b0;
      rd_both("R11 write beats ack", 8'h82, 8'h80);
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_filter();
      t_push_fill();
      t_pull();
      t_bypass_pull();
      t_reserved();
      t_collide();
      done = 1'b1;
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         report();
      end
   end

endmodule